// File: doc/BRIEF.md
# Eight-Pin GPIO Controller with Interrupt and Wake Masking

This block runs a bank of general-purpose pins through a small set of byte-wide registers. Each pin can be an input or an output. Output pins take their level from a data register. Every pin's sampled input passes through a synchroniser and an optional inversion. The corrected value is then readable as status, and two independent masks route it to an interrupt request and to a wake-event vector for the power-management logic.

A function-select bit takes over the two highest pins. When it is set, those pins drive the two bits of the current power state instead of register data. Pad buffers and host address decoding sit outside the block. The register port is a plain single-cycle access with no back-pressure: a write lands on the clock edge where `reg_wr` is high, and read data follows `reg_addr` combinationally. No stream data crosses the block, so there is no valid/ready handshake.

Top module: `gpio_pinmux_ctl`

## Requirements
- R1: After reset every register reads 0x00, `pin_oe` is all zero, `irq_od_oe` is 0 and `wake_evt` is 0.
- R2: Offset 0x02 is the direction register: it reads back what was written, and a 1 in bit i drives `pin_oe[i]` high.
- R3: Offset 0x03 is the output-data register: it reads back what was written, and bit i appears on `pin_out[i]` unless R8 overrides that pin.
- R4: Offset 0x07 is read-only and returns the synchronised pin levels XOR the polarity register; writes to it have no effect.
- R5: Offset 0x2A is the polarity register: a 1 in bit i inverts pin i before status, interrupt and wake logic.
- R6: Offset 0x05 is the interrupt mask: `irq_od_oe` (1 = pull the active-low interrupt line to 0) is high exactly while some corrected input with its mask bit set is 1.
- R7: Offset 0x29 is the wake mask: `wake_evt[i]` equals corrected input i AND mask bit i.
- R8: Bit 0 of offset 0x2B, when 1, makes `pin_out[6]` follow `pwr_state[1]` and `pin_out[7]` follow `pwr_state[0]`; the other bits of 0x2B read as 0.
- R9: Any other offset reads 0x00, and writes to it change no register.
- R10: A change on `pin_in` reaches status after exactly SYNC_STAGES rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Register offset for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| pin_in | input | 8 | Raw pin levels from the pads |
| pin_out | output | 8 | Levels to drive on output pins |
| pin_oe | output | 8 | Per-pin output enable |
| pwr_state | input | 2 | Current power state, routed out under R8 |
| irq_od_oe | output | 1 | Open-drain pull-down enable for the interrupt line |
| wake_evt | output | 8 | Masked wake events to power management |

## Verification
The bench builds the block with NPINS = 8 and SYNC_STAGES = 2. The eight pins are enough for the power-state override on pins 6 and 7 to sit beside ordinary pins, which the bench checks stay untouched. The two-stage synchroniser lets the bench check latency to the exact edge: the level is still old after one edge and new after the second. Polarity is toggled while the masks are set, so inversion is seen in the status, interrupt and wake paths alike.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [7:0] {
    OFS_DIR   = 8'h02,
    OFS_DOUT  = 8'h03,
    OFS_IRQM  = 8'h05,
    OFS_STAT  = 8'h07,
    OFS_WAKEM = 8'h29,
    OFS_POL   = 8'h2A,
    OFS_FSEL  = 8'h2B
  } reg_ofs_e;
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  dout_q,
  output logic [NPINS-1:0]  irqm_q,
  output logic [NPINS-1:0]  wakem_q,
  output logic [NPINS-1:0]  pol_q,
  output logic              fsel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      dout_q  <= '0;
      irqm_q  <= '0;
      wakem_q <= '0;
      pol_q   <= '0;
      fsel_q  <= 1'b0;
    end else if (wr) begin
      case (addr)
        ADDR_W'(OFS_DIR):   dir_q   <= wdata;
        ADDR_W'(OFS_DOUT):  dout_q  <= wdata;
        ADDR_W'(OFS_IRQM):  irqm_q  <= wdata;
        ADDR_W'(OFS_WAKEM): wakem_q <= wdata;
        ADDR_W'(OFS_POL):   pol_q   <= wdata;
        ADDR_W'(OFS_FSEL):  fsel_q  <= wdata[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] raw,
  output logic [NPINS-1:0] synced
);
  logic [NPINS-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      chain[s] <= '0;
        else if (s == 0) chain[s] <= raw;
        else             chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign synced = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
  parameter int NPINS = 8
) (
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] dout_q,
  input  logic             fsel_q,
  input  logic [1:0]       pwr_state,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);
  localparam int PIN_HI = NPINS - 1;
  localparam int PIN_LO = NPINS - 2;

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      assign pin_oe[i] = dir_q[i];
      if (i == PIN_LO) begin : g_ovr_lo
        assign pin_out[i] = fsel_q ? pwr_state[1] : dout_q[i];
      end else if (i == PIN_HI) begin : g_ovr_hi
        assign pin_out[i] = fsel_q ? pwr_state[0] : dout_q[i];
      end else begin : g_plain
        assign pin_out[i] = dout_q[i];
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_events.sv
module gpio_events #(
  parameter int NPINS = 8
) (
  input  logic [NPINS-1:0] synced,
  input  logic [NPINS-1:0] pol_q,
  input  logic [NPINS-1:0] irqm_q,
  input  logic [NPINS-1:0] wakem_q,
  output logic [NPINS-1:0] status,
  output logic             irq_od_oe,
  output logic [NPINS-1:0] wake_evt
);
  assign status    = synced ^ pol_q;
  assign irq_od_oe = |(status & irqm_q);
  assign wake_evt  = status & wakem_q;
endmodule

// File: rtl/gpio_pinmux_ctl.sv
module gpio_pinmux_ctl
  import gpio_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NPINS-1:0]  reg_wdata,
  output logic [NPINS-1:0]  reg_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  input  logic [1:0]        pwr_state,
  output logic              irq_od_oe,
  output logic [NPINS-1:0]  wake_evt
);
  logic [NPINS-1:0] dir_q, dout_q, irqm_q, wakem_q, pol_q;
  logic             fsel_q;
  logic [NPINS-1:0] synced, status;

  gpio_regfile #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .dir_q(dir_q), .dout_q(dout_q), .irqm_q(irqm_q), .wakem_q(wakem_q),
    .pol_q(pol_q), .fsel_q(fsel_q)
  );

  gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .synced(synced)
  );

  gpio_pin_drive #(.NPINS(NPINS)) u_drive (
    .dir_q(dir_q), .dout_q(dout_q), .fsel_q(fsel_q), .pwr_state(pwr_state),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  gpio_events #(.NPINS(NPINS)) u_evt (
    .synced(synced), .pol_q(pol_q), .irqm_q(irqm_q), .wakem_q(wakem_q),
    .status(status), .irq_od_oe(irq_od_oe), .wake_evt(wake_evt)
  );

  always_comb begin
    case (reg_addr)
      ADDR_W'(OFS_DIR):   reg_rdata = dir_q;
      ADDR_W'(OFS_DOUT):  reg_rdata = dout_q;
      ADDR_W'(OFS_IRQM):  reg_rdata = irqm_q;
      ADDR_W'(OFS_STAT):  reg_rdata = status;
      ADDR_W'(OFS_WAKEM): reg_rdata = wakem_q;
      ADDR_W'(OFS_POL):   reg_rdata = pol_q;
      ADDR_W'(OFS_FSEL):  reg_rdata = {{(NPINS-1){1'b0}}, fsel_q};
      default:            reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pinmux_ctl_chk.sv
module gpio_pinmux_ctl_chk
  import gpio_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [NPINS-1:0]  reg_wdata,
  input logic [NPINS-1:0]  reg_rdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic [1:0]        pwr_state,
  input logic              irq_od_oe,
  input logic [NPINS-1:0]  wake_evt,
  input logic [NPINS-1:0]  wakem_q,
  input logic              fsel_q
);
  logic known_ofs;
  always_comb begin
    known_ofs = (reg_addr == ADDR_W'(OFS_DIR))   || (reg_addr == ADDR_W'(OFS_DOUT)) ||
                (reg_addr == ADDR_W'(OFS_IRQM))  || (reg_addr == ADDR_W'(OFS_STAT)) ||
                (reg_addr == ADDR_W'(OFS_WAKEM)) || (reg_addr == ADDR_W'(OFS_POL))  ||
                (reg_addr == ADDR_W'(OFS_FSEL));
  end

  // R1: outputs quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (pin_oe == '0 && !irq_od_oe && wake_evt == '0)
        else $error("reset outputs not quiet");
    end
  end

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFS_DIR)) |=> (pin_oe == $past(reg_wdata)));

  p_dout_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFS_DOUT)) |=>
      (pin_out[NPINS-3:0] == $past(reg_wdata[NPINS-3:0])));

  p_wake_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((wake_evt & ~wakem_q) == '0));

  p_pwr_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fsel_q |-> (pin_out[NPINS-2] == pwr_state[1] && pin_out[NPINS-1] == pwr_state[0]));

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !known_ofs |-> (reg_rdata == '0));
endmodule

bind gpio_pinmux_ctl gpio_pinmux_ctl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .pwr_state(pwr_state), .irq_od_oe(irq_od_oe),
  .wake_evt(wake_evt), .wakem_q(wakem_q), .fsel_q(fsel_q)
);

// File: tb/sim_gpio_pinmux_ctl.sv
module sim_gpio_pinmux_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] pin_out, pin_oe, wake_evt;
  logic [1:0] pwr_state = 2'b00;
  logic       irq_od_oe;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pinmux_ctl #(.NPINS(8), .ADDR_W(8), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pwr_state(pwr_state),
    .irq_od_oe(irq_od_oe), .wake_evt(wake_evt)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk);
    pin_in = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    foreach (u_ofs[k]) begin
      rd(u_ofs[k], d);
      check("R1 reg reset", d, 8'h00);
    end
    check("R1 pin_oe", pin_oe, 8'h00);
    check("R1 irq", {7'd0, irq_od_oe}, 8'h00);
    check("R1 wake", wake_evt, 8'h00);
  endtask

  task automatic t_dir_out;
    logic [7:0] d;
    wr(8'h02, 8'hA5);
    rd(8'h02, d);
    check("R2 dir readback", d, 8'hA5);
    check("R2 pin_oe", pin_oe, 8'hA5);
    wr(8'h03, 8'h3C);
    rd(8'h03, d);
    check("R3 dout readback", d, 8'h3C);
    check("R3 pin_out", pin_out, 8'h3C);
  endtask

  task automatic t_status_pol;
    logic [7:0] d;
    set_pins(8'h96);
    rd(8'h07, d);
    check("R4 status", d, 8'h96);
    wr(8'h07, 8'hFF);
    rd(8'h07, d);
    check("R4 status write ignored", d, 8'h96);
    wr(8'h2A, 8'h0F);
    rd(8'h07, d);
    check("R5 status inverted", d, 8'h99);
    wr(8'h2A, 8'h00);
  endtask

  task automatic t_latency;
    logic [7:0] d;
    set_pins(8'h00);
    reg_addr = 8'h07;
    @(negedge clk);
    pin_in = 8'h01;
    @(negedge clk);
    #1 check("R10 one edge still old", reg_rdata, 8'h00);
    @(negedge clk);
    #1 check("R10 two edges new", reg_rdata, 8'h01);
    rd(8'h07, d);
  endtask

  task automatic t_irq;
    set_pins(8'h00);
    wr(8'h05, 8'h10);
    check("R6 irq idle", {7'd0, irq_od_oe}, 8'h00);
    set_pins(8'h10);
    check("R6 irq asserted", {7'd0, irq_od_oe}, 8'h01);
    set_pins(8'hEF);
    check("R6 unmasked pins no irq", {7'd0, irq_od_oe}, 8'h00);
    wr(8'h2A, 8'h10);
    check("R5 inversion raises irq", {7'd0, irq_od_oe}, 8'h01);
    wr(8'h2A, 8'h00);
    wr(8'h05, 8'h00);
  endtask

  task automatic t_wake;
    wr(8'h29, 8'h81);
    set_pins(8'hFF);
    check("R7 wake all high", wake_evt, 8'h81);
    set_pins(8'h80);
    check("R7 wake one", wake_evt, 8'h80);
    wr(8'h2A, 8'h01);
    check("R7 wake after inversion", wake_evt, 8'h81);
    wr(8'h2A, 8'h00);
    wr(8'h29, 8'h00);
  endtask

  task automatic t_override;
    logic [7:0] d;
    wr(8'h03, 8'h00);
    wr(8'h2B, 8'hFF);
    rd(8'h2B, d);
    check("R8 select readback", d, 8'h01);
    pwr_state = 2'b10;
    #1 check("R8 state 10", pin_out, 8'h40);
    pwr_state = 2'b01;
    #1 check("R8 state 01", pin_out, 8'h80);
    wr(8'h03, 8'h3F);
    check("R8 low pins keep data", pin_out, 8'hBF);
    wr(8'h2B, 8'h00);
    wr(8'h03, 8'hC0);
    check("R8 released", pin_out, 8'hC0);
  endtask

  task automatic t_reserved;
    logic [7:0] d;
    wr(8'h02, 8'h5A);
    wr(8'h04, 8'hFF);
    wr(8'h00, 8'hFF);
    wr(8'hC3, 8'hFF);
    rd(8'h04, d);
    check("R9 reserved read", d, 8'h00);
    rd(8'hC3, d);
    check("R9 high reserved read", d, 8'h00);
    rd(8'h02, d);
    check("R9 dir untouched", d, 8'h5A);
    rd(8'h2A, d);
    check("R9 pol untouched", d, 8'h00);
  endtask

  logic [7:0] u_ofs [7] = '{8'h02, 8'h03, 8'h05, 8'h07, 8'h29, 8'h2A, 8'h2B};

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {7'd0, irq_od_oe}, 8'h00);
    rst_n = 1'b1;
    t_reset();
    t_dir_out();
    t_status_pol();
    t_latency();
    t_irq();
    t_wake();
    t_override();
    t_reserved();
    finish_run();
  end
endmodule